// File: doc/BRIEF.md
# Clock Root Source Selector and Divider

This block is one slice of a clock root. Four candidate source clocks reach it as single-cycle tick strobes in the block's own clock domain. Software chooses one of them and an integer division ratio through a 32-bit control word. The block emits a divided tick stream, `root_tick`, which is one cycle high for every completed output period.

Changing the source or the ratio is never applied at once. The slice first holds its output low for one full period of the old setting. It then switches, restarts its divider from zero and clears a "changing" flag that software can poll. Writes made while a change is still running are kept in the control register. The value present when the running change completes is the one that gets applied. An off bit silences the output completely.

Top module: `clkroot_slice`

## Requirements
- R1: After reset the control word reads 0 (source 0, divide by 1, off clear), the status word reads 0, and `root_tick` pulses on every tick of source 0.
- R2: The control word is at address 0. It holds the ratio-minus-one in bits [7:0], the source index in bits [9:8] and the off flag in bit 24. Every other bit reads back as zero.
- R3: A ratio field of N gives one output tick for every N+1 ticks of the selected source, for every N from 0 to 255.
- R4: Source index k (0 to 3) selects `src_tick[k]` as the input to the divider.
- R5: Bit 0 of the status word at address 1 reads 1 from the cycle after a write that differs from the applied setting, and stays 1 until the new setting is in use.
- R6: While a change is pending on a running root, `root_tick` stays low for at least one full period of the old setting before the new setting takes over.
- R7: Once a change is applied, the divider restarts from zero. With source 0 and field N, the first output tick appears N+1 cycles after the changing bit is seen low.
- R8: A write made while the changing bit is set is held. When the running change completes, the most recent written value is the one applied.
- R9: With the off flag set, `root_tick` stays low. Leaving the off state applies the new setting within two cycles, with no drain period.
- R10: Writes to the status address have no effect on the control word or on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all source ticks are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_tick | input | 4 | One tick strobe per candidate source clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 status) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| root_tick | output | 1 | Divided output tick, one cycle per output period |

## Verification
On every cycle the assertions check four things. The divide counter never passes the applied ratio. The output stays silent while the slice is draining or switched off. A write to the status address leaves the control word unchanged. The exact output period for each source and ratio can only be shown by the bench scenarios, as can the length of the quiet gap around a change, the first-tick alignment after the restart, and the replacement of a pending write by a later one. Those scenarios measure tick spacing against a tick pattern that the bench generates itself.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;
  localparam int CKR_DIV_W   = 8;
  localparam int CKR_NSRC    = 4;
  localparam int CKR_SEL_W   = $clog2(CKR_NSRC);
  localparam int CKR_DATA_W  = 32;
  localparam int CKR_ADDR_W  = 2;
  localparam int CKR_SEL_LSB = 8;
  localparam int CKR_OFF_BIT = 24;
  localparam logic [CKR_ADDR_W-1:0] CKR_A_CTRL = 2'd0;
  localparam logic [CKR_ADDR_W-1:0] CKR_A_STAT = 2'd1;

  typedef struct packed {
    logic                 off;
    logic [CKR_SEL_W-1:0] sel;
    logic [CKR_DIV_W-1:0] div;
  } ckr_cfg_t;
endpackage

// File: rtl/clkroot_regs.sv
module clkroot_regs
  import clkroot_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CKR_ADDR_W-1:0] addr,
  input  logic [CKR_DATA_W-1:0] wdata,
  input  logic                  changing,
  output ckr_cfg_t              cfg,
  output logic [CKR_DATA_W-1:0] rdata
);
  ckr_cfg_t cfg_q, cfg_d;
  logic     ctrl_we;

  assign ctrl_we = wr_en && (addr == CKR_A_CTRL);

  always_comb begin
    cfg_d = cfg_q;
    if (ctrl_we) begin
      cfg_d.div = wdata[CKR_DIV_W-1:0];
      cfg_d.sel = wdata[CKR_SEL_LSB +: CKR_SEL_W];
      cfg_d.off = wdata[CKR_OFF_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      CKR_A_CTRL: begin
        rdata[CKR_DIV_W-1:0]            = cfg_q.div;
        rdata[CKR_SEL_LSB +: CKR_SEL_W] = cfg_q.sel;
        rdata[CKR_OFF_BIT]              = cfg_q.off;
      end
      CKR_A_STAT: rdata[0] = changing;
      default:    rdata = '0;
    endcase
  end

  assign cfg = cfg_q;

  // R10: status-address writes never disturb the control word
  a_r10_stat_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CKR_A_STAT) |=> (cfg_q == $past(cfg_q)));
endmodule

// File: rtl/clkroot_seq.sv
module clkroot_seq
  import clkroot_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ckr_cfg_t target,
  input  logic     term,
  output ckr_cfg_t active,
  output logic     cnt_clr,
  output logic     draining,
  output logic     changing
);
  typedef enum logic {SQ_RUN, SQ_DRAIN} sq_state_t;

  sq_state_t st_q, st_d;
  ckr_cfg_t  act_q, act_d;
  logic      differs;

  assign differs = (target != act_q);

  always_comb begin
    st_d    = st_q;
    act_d   = act_q;
    cnt_clr = 1'b0;
    case (st_q)
      SQ_RUN: begin
        if (differs) begin
          cnt_clr = 1'b1;
          if (act_q.off) act_d = target;
          else           st_d  = SQ_DRAIN;
        end
      end
      SQ_DRAIN: begin
        if (term) begin
          act_d   = target;
          cnt_clr = 1'b1;
          st_d    = SQ_RUN;
        end
      end
      default: st_d = SQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_RUN;
      act_q <= '0;
    end else begin
      st_q  <= st_d;
      act_q <= act_d;
    end
  end

  assign active   = act_q;
  assign draining = (st_q == SQ_DRAIN);
  assign changing = draining || differs;
endmodule

// File: rtl/clkroot_div.sv
module clkroot_div
  import clkroot_pkg::*;
#(
  parameter int NSRC  = CKR_NSRC,
  parameter int DIV_W = CKR_DIV_W,
  localparam int SEL_W = $clog2(NSRC)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  input  logic             clr,
  input  logic             gate,
  output logic             term,
  output logic             pulse
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick;
  logic             pulse_q, pulse_d;

  assign tick = src_tick[sel];
  assign term = tick && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (term) cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
    pulse_d = term && gate;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

  // R3: the period counter never runs past the applied ratio field
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div);
endmodule

// File: rtl/clkroot_slice.sv
module clkroot_slice
  import clkroot_pkg::*;
#(
  parameter int NSRC  = CKR_NSRC,
  parameter int DIV_W = CKR_DIV_W
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       src_tick,
  input  logic                  wr_en,
  input  logic [CKR_ADDR_W-1:0] addr,
  input  logic [CKR_DATA_W-1:0] wdata,
  output logic [CKR_DATA_W-1:0] rdata,
  output logic                  root_tick
);
  logic [1:0] rst_sync_q;
  logic       rst_i;
  ckr_cfg_t   tgt_cfg, act_cfg;
  logic       changing, draining, cnt_clr, term, gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  clkroot_regs u_regs (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .changing(changing), .cfg(tgt_cfg), .rdata(rdata)
  );

  clkroot_seq u_seq (
    .clk(clk), .rst_n(rst_i), .target(tgt_cfg), .term(term),
    .active(act_cfg), .cnt_clr(cnt_clr), .draining(draining), .changing(changing)
  );

  assign gate = !draining && !act_cfg.off;

  clkroot_div #(.NSRC(NSRC), .DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_i), .src_tick(src_tick), .sel(act_cfg.sel),
    .div(act_cfg.div), .clr(cnt_clr), .gate(gate), .term(term), .pulse(root_tick)
  );

  // R6: no output tick is produced out of a drain cycle
  a_r6_quiet_in_drain: assert property (@(posedge clk) disable iff (!rst_i)
    $past(draining) |-> !root_tick);

  // R9: a root that is switched off stays low
  a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_i)
    $past(act_cfg.off) |-> !root_tick);
endmodule

// File: tb/clkroot_slice_test.sv
module clkroot_slice_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  src_tick;
  logic        wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        root_tick;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  int ncyc     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int src_per(input int k);
    case (k)
      0: return 1;
      1: return 2;
      2: return 3;
      default: return 5;
    endcase
  endfunction

  always @(posedge clk) #1 cyc <= cyc + 1;
  always_comb
    for (int k = 0; k < 4; k++) src_tick[k] = ((cyc % src_per(k)) == 0);
  always @(negedge clk) ncyc <= ncyc + 1;

  clkroot_slice uut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .root_tick(root_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0; addr = 2'd0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] d;
    n = 0;
    forever begin
      rd(2'd1, d);
      if (!d[0] || n > 5000) break;
      n++;
    end
    addr = 2'd0;
  endtask

  task automatic measure(output int n);
    int w = 0;
    do begin @(negedge clk); w++; end while (!root_tick && w < 3000);
    n = 0;
    do begin @(negedge clk); n++; end while (!root_tick && n < 3000);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    int n;
    rd(2'd0, d); check(d == 32'h0, "R1 ctrl after reset", d, 0);
    rd(2'd1, d); check(d == 32'h0, "R1 status after reset", d, 0);
    measure(n);  check(n == 1, "R1 reset period", n, 1);
  endtask

  task automatic t_sources();
    int n, w;
    for (int s = 0; s < 4; s++) begin
      wr(2'd0, (32'(s) << 8) | 32'd1);
      wait_idle(w);
      measure(n);
      check(n == 2 * src_per(s), "R4 source select period", n, 2 * src_per(s));
    end
  endtask

  task automatic t_ratios();
    int n, w;
    wr(2'd0, 32'h0000_0203); wait_idle(w);
    measure(n); check(n == 12, "R3 ratio 4 on source 2", n, 12);
    wr(2'd0, 32'h0000_00FF); wait_idle(w);
    measure(n); check(n == 256, "R3 ratio 256 on source 0", n, 256);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    int w;
    wr(2'd0, 32'h00FE_F3A5);
    rd(2'd0, d); check(d == 32'h0000_03A5, "R2 field layout readback", d, 32'h3A5);
    wait_idle(w);
  endtask

  task automatic t_restart();
    int w, k;
    wr(2'd0, 32'h0000_0004);
    wait_idle(w);
    k = 0;
    do begin @(negedge clk); k++; end while (!root_tick && k < 100);
    check(k == 5, "R7 first tick after restart", k, 5);
  endtask

  task automatic t_drain();
    int n, w, t0, t1;
    wr(2'd0, 32'h0000_0104); wait_idle(w);
    measure(n);
    t0 = ncyc;
    wr(2'd0, 32'h0000_0000);
    wait_idle(w);
    check(w >= 1 && w < 5000, "R5 changing seen then cleared", w, 1);
    do @(negedge clk); while (!root_tick);
    t1 = ncyc;
    check((t1 - t0) >= 10, "R6 quiet gap covers old period", t1 - t0, 10);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    int n, w;
    wr(2'd0, 32'h0000_0309); wait_idle(w);
    wr(2'd0, 32'h0000_0000);
    wr(2'd0, 32'h0000_0102);
    rd(2'd1, d); check(d[0] == 1'b1, "R5 changing during drain", d, 1);
    wait_idle(w);
    rd(2'd0, d); check(d == 32'h0000_0102, "R8 latest write kept", d, 32'h102);
    measure(n); check(n == 6, "R8 latest write applied", n, 6);
    measure(n); check(n == 6, "R8 period stable", n, 6);
  endtask

  task automatic t_off();
    logic [31:0] d;
    int w, seen;
    wr(2'd0, 32'h0100_0000); wait_idle(w);
    rd(2'd0, d); check(d == 32'h0100_0000, "R9 off readback", d, 32'h0100_0000);
    seen = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (root_tick) seen++; end
    check(seen == 0, "R9 output low when off", seen, 0);
    wr(2'd0, 32'h0000_0000); wait_idle(w);
    check(w <= 2, "R9 leaving off is immediate", w, 2);
    measure(w); check(w == 1, "R9 runs after off", w, 1);
  endtask

  task automatic t_stat_write();
    logic [31:0] d;
    int n;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd0, d); check(d == 32'h0, "R10 ctrl untouched", d, 0);
    rd(2'd1, d); check(d == 32'h0, "R10 no change started", d, 0);
    measure(n);  check(n == 1, "R10 output untouched", n, 1);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_stat_write();
    t_sources();
    t_ratios();
    t_layout();
    t_restart();
    t_drain();
    t_pending();
    t_off();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule